// File: doc/BRIEF.md
# Self-Shifting Storage Words

This block holds four storage words, each 15 bits wide, at fixed consecutive addresses in a processor's data space. It sits on the processor's write path, ahead of general RAM. When a write lands on one of the four words, the word does not store the written value as given. It stores that value after a fixed transform, and each word has its own transform. A later read of the word therefore returns the shifted or rotated result, with no extra instruction needed. Software uses these words for cheap bit-field extraction and for scaling values in one's-complement form.

A write to any other address is passed on unchanged, in the same cycle, to a general RAM write port. Reads use a separate combinational read address. The read side returns the stored word and a hit flag when the address is one of the four words. The base address, the word width, the address width and the logical shift amount are all parameters.

Top module: `shiftcell_bank`

## Requirements
- R1: After reset, all four words read as zero.
- R2: A write to address BASE_ADDR+0 stores the written value rotated right by one bit: bit 0 moves to bit 14.
- R3: A write to address BASE_ADDR+1 stores the value shifted right arithmetically by one bit. Bit 14 is the sign bit; it is kept and also copied into bit 13.
- R4: A write to address BASE_ADDR+2 stores the value rotated left by one bit: bit 14 moves to bit 0.
- R5: A write to address BASE_ADDR+3 stores the value shifted right logically by LSR_AMT bits (default 7). The vacated upper bits are filled with zeros.
- R6: A write with wr_en high to an address outside BASE_ADDR..BASE_ADDR+3 drives ram_wr_en high in the same cycle, with ram_wr_addr and ram_wr_data equal to wr_addr and wr_data. None of the four words changes.
- R7: A write to one of the four words leaves the other three unchanged, and ram_wr_en stays low during it.
- R8: rd_hit is high exactly when rd_addr is one of the four addresses. rd_data then shows that word combinationally. Otherwise rd_data is zero.
- R9: While wr_en is low, no word changes and ram_wr_en is low, whatever wr_addr and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (12) | Write address |
| wr_data | input | WORD_W (15) | Write data |
| rd_addr | input | ADDR_W (12) | Read address |
| rd_data | output | WORD_W (15) | Stored word at rd_addr, or zero |
| rd_hit | output | 1 | rd_addr selects one of the four words |
| ram_wr_en | output | 1 | Write strobe passed on to general RAM |
| ram_wr_addr | output | ADDR_W (12) | Address passed on to general RAM |
| ram_wr_data | output | WORD_W (15) | Data passed on to general RAM |

## Verification
The bench writes patterns that expose each transform's edge bits:
- A lone bit 0 and a lone bit 14 catch a rotate built as a plain shift, which would lose the bit instead of wrapping it.
- Negative values such as 0x4000 and 0x7FFF catch an arithmetic shift that fills with zero, which would turn them positive.
- Values whose only set bits lie below the shift amount must read back as zero from the fourth word. A shift by the wrong amount leaves residue there.

After every write the bench reads back all four words. This catches a bad address decode, which would corrupt a neighbouring word or leak the write into the RAM port. A write with the strobe low, aimed at a word, must change nothing.

// File: rtl/shiftcell_pkg.sv
package shiftcell_pkg;

   // Transform applied by one storage word; the value is also the word's
   // offset from the base address, so the order is behavioural.
   typedef enum logic [1:0] {
      XF_ROR = 2'd0,
      XF_ASR = 2'd1,
      XF_ROL = 2'd2,
      XF_LSR = 2'd3
   } xform_e;

   localparam int NUM_CELLS = 4;

endpackage

// File: rtl/shiftcell_xform.sv
module shiftcell_xform
   import shiftcell_pkg::*;
#(
   parameter int     WORD_W    = 15,
   parameter xform_e KIND      = XF_ROR,
   parameter int     SHIFT_AMT = 7
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);

   localparam int MSB = WORD_W - 1;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("shiftcell_xform: WORD_W must be at least 2");
      end
      if (SHIFT_AMT < 1 || SHIFT_AMT >= WORD_W) begin : g_bad_shift
         $error("shiftcell_xform: SHIFT_AMT out of range");
      end

      case (KIND)
         XF_ROR: begin : g_ror
            assign dout = {din[0], din[MSB:1]};
            always_comb begin
               if (!$isunknown(din)) begin
                  // R2
                  ror_keeps_ones_chk: assert ($countones(dout) == $countones(din))
                     else $error("ror lost or gained bits");
               end
            end
         end
         XF_ASR: begin : g_asr
            assign dout = {din[MSB], din[MSB:1]};
            always_comb begin
               if (!$isunknown(din)) begin
                  // R3
                  asr_sign_chk: assert (dout[MSB] == din[MSB] && dout[MSB-1] == din[MSB])
                     else $error("asr sign not preserved");
               end
            end
         end
         XF_ROL: begin : g_rol
            assign dout = {din[MSB-1:0], din[MSB]};
            always_comb begin
               if (!$isunknown(din)) begin
                  // R4
                  rol_keeps_ones_chk: assert ($countones(dout) == $countones(din))
                     else $error("rol lost or gained bits");
               end
            end
         end
         default: begin : g_lsr
            assign dout = din >> SHIFT_AMT;
            always_comb begin
               if (!$isunknown(din)) begin
                  // R5
                  lsr_zero_fill_chk: assert (dout[MSB -: SHIFT_AMT] == '0)
                     else $error("lsr did not zero fill");
               end
            end
         end
      endcase
   endgenerate

endmodule

// File: rtl/shiftcell_decode.sv
module shiftcell_decode #(
   parameter int          ADDR_W    = 12,
   parameter int          N         = 4,
   parameter int unsigned BASE_ADDR = 16
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [N-1:0]      sel,
   output logic              hit
);

   generate
      if (BASE_ADDR + N > (1 << ADDR_W)) begin : g_bad_base
         $error("shiftcell_decode: address window exceeds address space");
      end
      for (genvar i = 0; i < N; i++) begin : g_sel
         localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(BASE_ADDR + i);
         assign sel[i] = en && (addr == MATCH);
      end
   endgenerate

   assign hit = |sel;

endmodule

// File: rtl/shiftcell_word.sv
module shiftcell_word #(
   parameter int WORD_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we) q <= d;
   end

   // R7
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q))
      else $error("storage word changed without its strobe");

endmodule

// File: rtl/shiftcell_bank.sv
module shiftcell_bank
   import shiftcell_pkg::*;
#(
   parameter int          WORD_W    = 15,
   parameter int          ADDR_W    = 12,
   parameter int unsigned BASE_ADDR = 16,
   parameter int          LSR_AMT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_hit,
   output logic              ram_wr_en,
   output logic [ADDR_W-1:0] ram_wr_addr,
   output logic [WORD_W-1:0] ram_wr_data
);

   localparam int MSB = WORD_W - 1;
   localparam logic [ADDR_W-1:0] A_ROR = ADDR_W'(BASE_ADDR + 0);
   localparam logic [ADDR_W-1:0] A_ASR = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_LSR = ADDR_W'(BASE_ADDR + 3);

   logic [NUM_CELLS-1:0]        wr_sel, rd_sel;
   logic                        wr_hit;
   logic [WORD_W-1:0]           xf_out [NUM_CELLS];
   logic [WORD_W-1:0]           cell_q [NUM_CELLS];
   logic [NUM_CELLS*WORD_W-1:0] cells_flat;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("shiftcell_bank: ADDR_W too small");
      end
   endgenerate

   shiftcell_decode #(.ADDR_W(ADDR_W), .N(NUM_CELLS), .BASE_ADDR(BASE_ADDR)) u_wr_dec (
      .en(wr_en), .addr(wr_addr), .sel(wr_sel), .hit(wr_hit)
   );

   shiftcell_decode #(.ADDR_W(ADDR_W), .N(NUM_CELLS), .BASE_ADDR(BASE_ADDR)) u_rd_dec (
      .en(1'b1), .addr(rd_addr), .sel(rd_sel), .hit(rd_hit)
   );

   generate
      for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
         shiftcell_xform #(
            .WORD_W(WORD_W), .KIND(xform_e'(i)), .SHIFT_AMT(LSR_AMT)
         ) u_xf (
            .din(wr_data), .dout(xf_out[i])
         );
         shiftcell_word #(.WORD_W(WORD_W)) u_word (
            .clk(clk), .rst_n(rst_n), .we(wr_sel[i]), .d(xf_out[i]), .q(cell_q[i])
         );
         assign cells_flat[i*WORD_W +: WORD_W] = cell_q[i];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CELLS; i++) begin
         if (rd_sel[i]) rd_data = cell_q[i];
      end
   end

   assign ram_wr_en   = wr_en && !wr_hit;
   assign ram_wr_addr = wr_addr;
   assign ram_wr_data = wr_data;

   // R2
   ror_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_ROR) |=> cell_q[0] == {$past(wr_data[0]), $past(wr_data[MSB:1])})
      else $error("rotate-right word stored wrong value");

   // R3
   asr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_ASR) |=> cell_q[1][MSB] == $past(wr_data[MSB]))
      else $error("arithmetic word lost its sign");

   // R5
   lsr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_LSR) |=> cell_q[3][MSB -: LSR_AMT] == '0)
      else $error("logical word upper bits not zero");

   // R6
   passthru_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_en |=> $stable(cells_flat))
      else $error("pass-through write touched a storage word");

   // R8
   rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> rd_data == '0)
      else $error("read miss returned nonzero data");

   // R9
   idle_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !ram_wr_en)
      else $error("ram strobe without write strobe");

endmodule

// File: tb/tb_shiftcell_bank.sv
`timescale 1ns/1ps
module tb_shiftcell_bank;

   localparam int W    = 15;
   localparam int AW   = 12;
   localparam int BASE = 16;
   localparam int LSRN = 7;

   typedef struct {
      logic [AW-1:0] addr;
      logic [W-1:0]  val;
      logic          hit;
      string         req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic          rd_hit;
   logic          ram_wr_en;
   logic [AW-1:0] ram_wr_addr;
   logic [W-1:0]  ram_wr_data;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   item_t sb[$];
   logic [W-1:0] model [4];

   shiftcell_bank #(.WORD_W(W), .ADDR_W(AW), .BASE_ADDR(BASE), .LSR_AMT(LSRN)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
      .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
   );

   always #4 clk = ~clk;

   function automatic logic [W-1:0] expect_of(int idx, logic [W-1:0] v);
      case (idx)
         0: return {v[0], v[14:1]};
         1: return {v[14], v[14], v[13:1]};
         2: return {v[13:0], v[14]};
         default: return {7'b0, v[14:7]};
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_all(string req);
      for (int i = 0; i < 4; i++) begin
         item_t it;
         it.addr = AW'(BASE + i);
         it.val  = model[i];
         it.hit  = 1'b1;
         it.req  = req;
         sb.push_back(it);
      end
   endtask

   task automatic push_miss(logic [AW-1:0] a, string req);
      item_t it;
      it.addr = a;
      it.val  = '0;
      it.hit  = 1'b0;
      it.req  = req;
      sb.push_back(it);
   endtask

   // driver: one write, check the RAM port, update model, queue readbacks
   task automatic do_write(logic en, logic [AW-1:0] a, logic [W-1:0] d, string req);
      int idx;
      bit in_win;
      idx = int'(a) - BASE;
      in_win = (idx >= 0 && idx < 4);
      @(negedge clk);
      wr_en = en; wr_addr = a; wr_data = d;
      #1;
      if (!en) begin
         check("R9", {31'b0, ram_wr_en}, 32'd0);
      end else if (in_win) begin
         check("R7", {31'b0, ram_wr_en}, 32'd0);
      end else begin
         check("R6", {31'b0, ram_wr_en}, 32'd1);
         check("R6", {20'b0, ram_wr_addr}, {20'b0, a});
         check("R6", {17'b0, ram_wr_data}, {17'b0, d});
      end
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (en && in_win) model[idx] = expect_of(idx, d);
      push_all(req);
      wait (sb.size() == 0);
   endtask

   // monitor: pop one expected item per cycle and compare the read port
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         rd_addr = it.addr;
         #1;
         check(it.req, {17'b0, rd_data}, {17'b0, it.val});
         check("R8", {31'b0, rd_hit}, {31'b0, it.hit});
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      push_all("R1");
      push_miss(AW'(BASE + 4), "R8");
      push_miss(AW'(BASE - 1), "R8");
      wait (sb.size() == 0);

      // R2 rotate right: wrap of bit 0, general pattern
      do_write(1'b1, AW'(BASE + 0), 15'h0001, "R2");
      do_write(1'b1, AW'(BASE + 0), 15'h2AAA, "R2");
      // R3 arithmetic right: negative, all ones, positive
      do_write(1'b1, AW'(BASE + 1), 15'h4000, "R3");
      do_write(1'b1, AW'(BASE + 1), 15'h7FFF, "R3");
      do_write(1'b1, AW'(BASE + 1), 15'h3FFE, "R3");
      // R4 rotate left: wrap of bit 14
      do_write(1'b1, AW'(BASE + 2), 15'h4000, "R4");
      do_write(1'b1, AW'(BASE + 2), 15'h1234, "R4");
      // R5 logical right by 7
      do_write(1'b1, AW'(BASE + 3), 15'h7FFF, "R5");
      do_write(1'b1, AW'(BASE + 3), 15'h007F, "R5");
      do_write(1'b1, AW'(BASE + 3), 15'h5580, "R5");
      // R6 pass-through just outside the window on both sides
      do_write(1'b1, AW'(BASE + 4), 15'h1357, "R6");
      do_write(1'b1, AW'(BASE - 1), 15'h7531, "R6");
      do_write(1'b1, 12'hFFF, 15'h0F0F, "R6");
      // R9 strobe low aimed at each word
      for (int i = 0; i < 4; i++) do_write(1'b0, AW'(BASE + i), 15'h5A5A, "R9");
      // R7 neighbours untouched after a write to word 1
      do_write(1'b1, AW'(BASE + 1), 15'h0003, "R7");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule